// File: doc/BRIEF.md
# Five-Lane Parallel FIR Filter

This block filters a sample stream that arrives five samples at a time, as it does when a converter runs faster than the fabric clock and its words are delivered side by side. On every clock that carries valid data the block takes five new samples into one shared window register and moves that window along by five positions. Five multiply-accumulate phases look at different offsets of the same window, so each clock yields five filtered output samples. The filter does not decimate, so five samples go in and five come out.

The tap count, sample width, coefficient width and coefficient values are parameters; the coefficients are fixed when the block is built. Products and sums are kept at full precision, and each phase output is a slice of the accumulator: a chosen number of low bits is discarded and all the bits above them are kept. A fixed pipeline of three registers separates an input word from the output word it produces. While input valid is low the window does not move, and the output holds its last value.

Top module: `fir_par5`

## Requirements
- R1: Input lane k (bits [12k+11:12k] of `inSamples`, two's complement) is the sample at time n+k of the block, so lane 0 is the oldest and lane 4 the newest of the five.
- R2: Output lane k (bits [16k+15:16k] of `outSamples`) is derived from acc_k = sum over i=0..TAPS-1 of h[i]·x[n+k−i], where coefficient h[i] is the signed field at bits [12i+11:12i] of `COEFS`.
- R3: Each valid input word moves the window on by exactly five samples, so the response to one sample runs on into the output words of later blocks.
- R4: When `inValid` is low the samples on `inSamples` are ignored and the window holds, so the next valid block continues the filter as if the gap had not been there.
- R5: `outValid` equals `inValid` delayed by exactly three clocks.
- R6: Each output lane is bits [OUT_DROP+15:OUT_DROP] of the 28-bit full-precision accumulator, with OUT_DROP = 12 by default.
- R7: While `outValid` is low, `outSamples` keeps its previous value.
- R8: Synchronous reset (`rst` high) clears the window, the pipeline and the outputs: `outValid` is 0, `outSamples` is 0, and samples from before the reset act as zeros afterwards.
- R9: The sum does not wrap for any input: words of full-scale samples with alternating signs, whose sums exceed a 24-bit range, produce the exactly computed slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | The five samples on `inSamples` are valid this clock |
| inSamples | input | 60 | Five signed 12-bit samples, lane 0 oldest |
| outValid | output | 1 | `outSamples` carries a new result word |
| outSamples | output | 80 | Five signed 16-bit filtered samples, lane k is phase k |

## Verification
Single impulses placed on lane 0 and on lane 3 show the coefficient set spread across the five phases and into the following blocks. They separate a correct lane order and window stride from a reversed or mis-strided one. Constant full-scale positive and negative words, mixed-sign words and alternating full-scale words check the signed multiply and show whether the accumulator keeps its full width. Bubbles carrying junk samples and a reset applied while data is in flight show whether the window freezes and clears when it should, and whether the three-clock valid pipeline matches the data it goes with.

// File: rtl/fir_par5_pkg.sv
package fir_par5_pkg;

  // Strobes the control issues to the datapath, one per pipeline stage.
  typedef struct packed {
    logic loadWin;   // shift five new samples into the window
    logic loadProd;  // capture the tap products
    logic loadOut;   // capture the summed, sliced result
  } firStrobe_t;

  // Full-precision accumulator width: product width, growth from the sum of
  // TAPS terms, and one guard bit.
  function automatic int accWidth(input int sw, input int cw, input int taps);
    return sw + cw + $clog2(taps) + 1;
  endfunction

endpackage

// File: rtl/fir_par5_ctrl.sv
module fir_par5_ctrl
  import fir_par5_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output firStrobe_t strobe,
  output logic       outValid
);

  // stageValid[0]: the window holds a new block; stageValid[1]: products are ready
  logic [1:0] stageValid;
  logic       outValidReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid  <= '0;
      outValidReg <= 1'b0;
    end else begin
      stageValid  <= {stageValid[0], inValid};
      outValidReg <= stageValid[1];
    end
  end

  always_comb begin
    strobe.loadWin  = inValid;
    strobe.loadProd = stageValid[0];
    strobe.loadOut  = stageValid[1];
  end

  assign outValid = outValidReg;

endmodule

// File: rtl/fir_par5_phase.sv
module fir_par5_phase
  import fir_par5_pkg::*;
#(
  parameter int                        SAMPLE_W = 12,
  parameter int                        COEF_W   = 12,
  parameter int                        TAPS     = 8,
  parameter logic [TAPS*COEF_W-1:0]    COEFS    = '0,
  parameter int                        OUT_DROP = 12,
  localparam int                       ACC_W    = accWidth(SAMPLE_W, COEF_W, TAPS),
  localparam int                       OUT_W    = ACC_W - OUT_DROP
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     loadProd,
  input  logic                     loadOut,
  input  logic [TAPS*SAMPLE_W-1:0] tapBus,   // tap i holds x[n+k-i]
  output logic [OUT_W-1:0]         result
);

  localparam int PROD_W = SAMPLE_W + COEF_W;

  logic signed [COEF_W-1:0] coef     [TAPS];
  logic signed [PROD_W-1:0] prodNext [TAPS];
  logic signed [PROD_W-1:0] prodReg  [TAPS];
  logic signed [ACC_W-1:0]  accSum;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign coef[i]     = COEFS[i*COEF_W +: COEF_W];
    assign prodNext[i] = $signed(tapBus[i*SAMPLE_W +: SAMPLE_W]) * coef[i];
  end

  // Stage 2: one register per product keeps the adder tree off the multiplier path.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) prodReg[i] <= '0;
    end else if (loadProd) begin
      for (int i = 0; i < TAPS; i++) prodReg[i] <= prodNext[i];
    end
  end

  // Full-precision signed sum of all products.
  always_comb begin
    accSum = '0;
    for (int i = 0; i < TAPS; i++) accSum = accSum + ACC_W'(prodReg[i]);
  end

  // Stage 3: keep the bits above the dropped LSBs.
  always_ff @(posedge clk) begin
    if (rst)          result <= '0;
    else if (loadOut) result <= accSum[OUT_DROP +: OUT_W];
  end

  if (OUT_DROP > 0) begin : g_drop
    logic unusedLowBits;
    assign unusedLowBits = ^accSum[OUT_DROP-1:0];
  end

endmodule

// File: rtl/fir_par5_dp.sv
module fir_par5_dp
  import fir_par5_pkg::*;
#(
  parameter int                     LANES    = 5,
  parameter int                     SAMPLE_W = 12,
  parameter int                     COEF_W   = 12,
  parameter int                     TAPS     = 8,
  parameter logic [TAPS*COEF_W-1:0] COEFS    = '0,
  parameter int                     OUT_DROP = 12,
  localparam int                    OUT_W    = accWidth(SAMPLE_W, COEF_W, TAPS) - OUT_DROP
)(
  input  logic                      clk,
  input  logic                      rst,
  input  firStrobe_t                strobe,
  input  logic [LANES*SAMPLE_W-1:0] inSamples,
  output logic [LANES*OUT_W-1:0]    outSamples
);

  // Window ordered by age: entry 0 is the newest sample, x[n+LANES-1].
  localparam int WIN_LEN = TAPS + LANES - 1;

  logic [SAMPLE_W-1:0] winReg  [WIN_LEN];
  logic [SAMPLE_W-1:0] winNext [WIN_LEN];

  for (genvar j = 0; j < WIN_LEN; j++) begin : g_win
    if (j < LANES) begin : g_new
      // newest lane lands at the front
      assign winNext[j] = inSamples[(LANES-1-j)*SAMPLE_W +: SAMPLE_W];
    end else begin : g_old
      // older samples move back by one block
      assign winNext[j] = winReg[j-LANES];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < WIN_LEN; j++) winReg[j] <= '0;
    end else if (strobe.loadWin) begin
      for (int j = 0; j < WIN_LEN; j++) winReg[j] <= winNext[j];
    end
  end

  // Phase k, tap i reads x[n+k-i], found at window entry LANES-1-k+i.
  for (genvar k = 0; k < LANES; k++) begin : g_phase
    logic [TAPS*SAMPLE_W-1:0] tapBus;

    for (genvar i = 0; i < TAPS; i++) begin : g_sel
      assign tapBus[i*SAMPLE_W +: SAMPLE_W] = winReg[LANES-1-k+i];
    end

    fir_par5_phase #(
      .SAMPLE_W (SAMPLE_W),
      .COEF_W   (COEF_W),
      .TAPS     (TAPS),
      .COEFS    (COEFS),
      .OUT_DROP (OUT_DROP)
    ) phase_i (
      .clk      (clk),
      .rst      (rst),
      .loadProd (strobe.loadProd),
      .loadOut  (strobe.loadOut),
      .tapBus   (tapBus),
      .result   (outSamples[k*OUT_W +: OUT_W])
    );
  end

endmodule

// File: rtl/fir_par5.sv
module fir_par5
  import fir_par5_pkg::*;
#(
  parameter int                     LANES    = 5,
  parameter int                     SAMPLE_W = 12,
  parameter int                     COEF_W   = 12,
  parameter int                     TAPS     = 8,
  // h[i] at bits [COEF_W*i +: COEF_W]: 1, 2, -3, 4, 100, -2048, 2047, -1
  parameter logic [TAPS*COEF_W-1:0] COEFS    = {12'hFFF, 12'h7FF, 12'h800, 12'h064,
                                                12'h004, 12'hFFD, 12'h002, 12'h001},
  parameter int                     OUT_DROP = 12,
  localparam int                    OUT_W    = accWidth(SAMPLE_W, COEF_W, TAPS) - OUT_DROP
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  input  logic [LANES*SAMPLE_W-1:0] inSamples,
  output logic                      outValid,
  output logic [LANES*OUT_W-1:0]    outSamples
);

  firStrobe_t strobe;

  fir_par5_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fir_par5_dp #(
    .LANES    (LANES),
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .TAPS     (TAPS),
    .COEFS    (COEFS),
    .OUT_DROP (OUT_DROP)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .inSamples  (inSamples),
    .outSamples (outSamples)
  );

endmodule

// File: rtl/fir_par5_chk.sv
module fir_par5_chk #(
  parameter int LANES    = 5,
  parameter int SAMPLE_W = 12,
  parameter int TAPS     = 8,
  parameter int OUT_W    = 16
)(
  input logic                      clk,
  input logic                      rst,
  input logic                      inValid,
  input logic [LANES*SAMPLE_W-1:0] inSamples,
  input logic                      outValid,
  input logic [LANES*OUT_W-1:0]    outSamples
);

  // Consecutive all-zero valid blocks needed before the whole window is zero.
  localparam int NEED = (TAPS + LANES - 2) / LANES + 1;

  logic [3:0] zeroRun;
  logic [2:0] zeroPipe;
  logic [1:0] sinceRst;
  logic       blockZero;

  assign blockZero = (inSamples == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      zeroRun  <= '0;
      zeroPipe <= '0;
      sinceRst <= '0;
    end else begin
      if (inValid) zeroRun <= blockZero ? ((zeroRun == 4'hF) ? zeroRun : zeroRun + 4'd1) : 4'd0;
      zeroPipe <= {zeroPipe[1:0], inValid && blockZero && (int'(zeroRun) + 1 >= NEED)};
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
    end
  end

  // R5: output valid trails input valid by three clocks
  a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R7: no new valid word, no change on the output
  a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && !outValid) |-> $stable(outSamples));

  // R8: first clock out of reset shows a cleared output
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!outValid && outSamples == '0));

  // R2: a window full of zeros gives zero on every phase
  a_r2_zero_window: assert property (@(posedge clk) disable iff (rst)
    (outValid && zeroPipe[2]) |-> (outSamples == '0));

endmodule

bind fir_par5 fir_par5_chk #(
  .LANES    (LANES),
  .SAMPLE_W (SAMPLE_W),
  .TAPS     (TAPS),
  .OUT_W    (OUT_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inSamples  (inSamples),
  .outValid   (outValid),
  .outSamples (outSamples)
);

// File: tb/fir_par5_tb_top.sv
module fir_par5_tb_top;

  localparam int CLK_P    = 10;
  localparam int LANES    = 5;
  localparam int SAMPLE_W = 12;
  localparam int COEF_W   = 12;
  localparam int TAPS     = 8;
  localparam int OUT_DROP = 12;
  localparam int OUT_W    = 16;
  localparam int COEF_INT [TAPS] = '{1, 2, -3, 4, 100, -2048, 2047, -1};
  localparam logic [TAPS*COEF_W-1:0] TB_COEFS = {12'hFFF, 12'h7FF, 12'h800, 12'h064,
                                                 12'h004, 12'hFFD, 12'h002, 12'h001};

  // {valid, lane4 .. lane0}
  localparam int NSTIM = 18;
  localparam logic [60:0] STIM [NSTIM] = '{
    {1'b1, 60'h000_000_000_000_001},  // impulse on lane 0
    {1'b1, 60'h000_000_000_000_000},
    {1'b1, 60'h000_000_000_000_000},
    {1'b1, 60'h000_7FF_000_000_000},  // impulse on lane 3
    {1'b1, 60'h000_000_000_000_000},
    {1'b0, 60'hABC_ABC_ABC_ABC_ABC},  // junk during bubble
    {1'b1, 60'h000_000_000_000_000},
    {1'b1, 60'h000_000_000_000_000},
    {1'b1, 60'h7FF_7FF_7FF_7FF_7FF},
    {1'b1, 60'h800_800_800_800_800},
    {1'b1, 60'h800_800_800_800_800},
    {1'b1, 60'h7FF_800_7FF_800_7FF},
    {1'b0, 60'h555_555_555_555_555},
    {1'b1, 60'h123_F00_0A5_800_7FF},
    {1'b1, 60'h800_7FF_800_7FF_800},
    {1'b1, 60'h000_000_000_000_000},
    {1'b1, 60'h000_000_000_000_000},
    {1'b1, 60'h000_000_000_000_000}
  };
  string stimTag [NSTIM] = '{"R1", "R3", "R3", "R1", "R3", "R4", "R4", "R3", "R2",
                             "R6", "R9", "R9", "R4", "R2", "R9", "R3", "R3", "R3"};

  logic                      clk = 1'b0;
  logic                      rst;
  logic                      inValid;
  logic [LANES*SAMPLE_W-1:0] inSamples;
  logic                      outValid;
  logic [LANES*OUT_W-1:0]    outSamples;

  int checks = 0;
  int fails  = 0;

  int                     sampleLog [1024];
  int                     nSamp;
  int                     cyc;
  logic                   expV [256];
  logic [LANES*OUT_W-1:0] expD [256];
  logic [LANES*OUT_W-1:0] heldD;

  always #(CLK_P/2) clk = ~clk;

  fir_par5 #(
    .LANES    (LANES),
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .TAPS     (TAPS),
    .COEFS    (TB_COEFS),
    .OUT_DROP (OUT_DROP)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .inSamples  (inSamples),
    .outValid   (outValid),
    .outSamples (outSamples)
  );

  task automatic checkBit(input string tag, input logic got, input logic want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s outValid got %0b expected %0b (cycle %0d)", tag, got, want, cyc);
    end
  endtask

  task automatic checkWord(input string tag, input logic [LANES*OUT_W-1:0] got,
                           input logic [LANES*OUT_W-1:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s outSamples got %h expected %h (cycle %0d)", tag, got, want, cyc);
    end
  endtask

  // One clock: drive a word, update the model, compare the output two edges late.
  task automatic step(input logic [60:0] word, input string tag);
    logic                   eV;
    logic [LANES*OUT_W-1:0] eD;
    int                     c;
    @(negedge clk);
    inValid   = word[60];
    inSamples = word[59:0];
    @(posedge clk);
    if (word[60]) begin
      for (int k = 0; k < LANES; k++) begin
        logic [SAMPLE_W-1:0] raw;
        raw = word[k*SAMPLE_W +: SAMPLE_W];
        sampleLog[nSamp+k] = int'($signed(raw));
      end
      for (int k = 0; k < LANES; k++) begin
        longint acc;
        acc = 0;
        for (int i = 0; i < TAPS; i++) begin
          int idx;
          idx = nSamp + k - i;
          if (idx >= 0) acc += longint'(COEF_INT[i]) * longint'(sampleLog[idx]);
        end
        heldD[k*OUT_W +: OUT_W] = OUT_W'(acc >>> OUT_DROP);
      end
      nSamp += LANES;
    end
    expV[cyc] = word[60];
    expD[cyc] = heldD;
    #1;
    c  = cyc - 2;
    eV = (c >= 0) ? expV[c] : 1'b0;
    eD = (c >= 0) ? expD[c] : '0;
    checkBit("R5", outValid, eV);
    checkWord(eV ? tag : "R7", outSamples, eD);
    cyc++;
  endtask

  // Reset with junk valid data on the inputs; outputs must come up cleared.
  task automatic doReset();
    @(negedge clk);
    rst       = 1'b1;
    inValid   = 1'b1;
    inSamples = {LANES{12'hFFF}};
    repeat (2) @(posedge clk);
    #1;
    checkBit("R8", outValid, 1'b0);
    checkWord("R8", outSamples, '0);
    @(negedge clk);
    rst     = 1'b0;
    inValid = 1'b0;
    nSamp   = 0;
    cyc     = 0;
    heldD   = '0;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst       = 1'b1;
    inValid   = 1'b0;
    inSamples = '0;
    nSamp     = 0;
    cyc       = 0;
    heldD     = '0;
    doReset();

    // Table walk: lane order, window stride, bubbles, extremes.
    for (int v = 0; v < NSTIM; v++) step(STIM[v], stimTag[v]);
    for (int d = 0; d < 4; d++) step({1'b0, 60'h0}, "R7");

    // R5: lone valid word after reset, then idle.
    doReset();
    step({1'b1, 60'h001_000_000_000_000}, "R5");
    for (int d = 0; d < 4; d++) step({1'b0, 60'hFFF_FFF_FFF_FFF_FFF}, "R7");

    // R4: long bubble with junk between an impulse and its tail.
    step({1'b1, 60'h000_000_3A0_000_000}, "R4");
    for (int d = 0; d < 6; d++) step({1'b0, 60'h7FF_123_800_456_FFF}, "R4");
    step({1'b1, 60'h000_000_000_000_000}, "R4");
    step({1'b1, 60'h000_000_000_000_000}, "R4");
    for (int d = 0; d < 3; d++) step({1'b0, 60'h0}, "R7");

    // R8: reset in flight clears the window; later zeros give zero outputs.
    step({1'b1, 60'h7FF_7FF_7FF_7FF_7FF}, "R9");
    step({1'b1, 60'h800_800_800_800_800}, "R9");
    doReset();
    step({1'b1, 60'h000_000_000_000_000}, "R8");
    step({1'b1, 60'h000_000_000_000_000}, "R8");
    for (int d = 0; d < 3; d++) step({1'b0, 60'h0}, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule